// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block holds the software-visible registers of a simple LCD controller: a control word, three timing words, a status word and a subpanel word, all on a 32-bit register bus at byte offsets 0x00 to 0x14. Some stored fields read back merged with fixed constant bits. The panel width and height are written as the value minus one.

Three status flags are set by one-cycle strobes from the fetch logic: frame done, palette done and sync error. The block folds them into one level interrupt. Frame done and palette done each have their own enable bit. Sync error cannot be masked. Each time software changes the enable bit, the block emits a one-cycle pulse for the fetch logic. Writing enable from 1 to 0 also clears sync error and sets frame done, except in palette loading mode 1. An access to an offset with no register behind it reads zero and sets a sticky error output.

Top module: `lcd_regs`

## Requirements
- R1: After reset all stored fields and flags are zero. Reads then return: control 0xfe000c34, timing0 0x0000000f, timing1 0, timing2 0xfc000000, status 0, subpanel 0. `irq`, `en_change` and `bad_access` are low.
- R2: A write to offset 0x00 stores the following fields:
  - bit 0: enable
  - bit 1: mono
  - bits 4:3: interrupt enables, where bit 3 gates frame done and bit 4 gates palette done
  - bit 7: TFT mode
  - bits 21:20: palette loading mode
  - all bits under mask 0x01cff300, kept as written
  
  A read returns all stored fields, plus the TFT bit copied into bit 23, ORed with 0xfe000c34.
- R3: Offsets 0x04 and 0x08 store the whole written word. Bits 9:0 hold width-1 and height-1. A timing0 read forces bits 3:0 to 1. A timing1 read returns the word unchanged.
- R4: Offset 0x0c stores the whole word and reads back with bits 31:26 forced to 1.
- R5: Offset 0x14 stores the written value ANDed with 0xa1ffffff.
- R6: Offset 0x10 is status and is read-only. Bit 0 is frame done, bit 2 is sync error and bit 6 is palette done; all other bits read 0. A set strobe sets its flag on the next edge. Writes to this offset leave the status unchanged.
- R7: `irq` is high when any of these holds, and low otherwise:
  - frame done is set and interrupt enable bit 3 is set
  - palette done is set and interrupt enable bit 4 is set
  - sync error is set, whatever the enables
- R8: A control write whose bit 0 differs from the stored enable drives `en_change` high for exactly the one cycle after the write edge. A control write with the same enable value gives no pulse. `panel_on` follows the stored enable.
- R9: A control write that changes enable from 1 to 0 clears sync error. In the same write, frame done is set unless the newly written loading mode is 1. A set strobe in the same cycle wins over this clear.
- R10: A read or write at any offset other than 0x00, 0x04, 0x08, 0x0c, 0x10 or 0x14 reads 0 and changes no register. It also sets `bad_access`, which stays high until reset.
- R11: Read data is registered: it is valid one cycle after the cycle in which `rd_en` is sampled. It holds when `rd_en` is low. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| set_frame_done | input | 1 | Sets the frame done flag |
| set_palette_done | input | 1 | Sets the palette done flag |
| set_sync_error | input | 1 | Sets the sync error flag |
| irq | output | 1 | Level interrupt |
| en_change | output | 1 | One-cycle pulse when the enable bit changes |
| panel_on | output | 1 | Current enable bit |
| bad_access | output | 1 | Sticky flag for accesses to unmapped offsets |

## Verification
Every result is due one edge after its stimulus:
- register contents, flags and `bad_access` change at the edge that samples the write or strobe;
- `irq` follows the flags combinationally in the same cycle;
- `en_change` is high only in the cycle after the control write;
- `rdata` shows the addressed value after the edge that samples `rd_en`.

The bench drives inputs on the falling edge and returns from each access task at the next falling edge, half a cycle after the active edge, so each check samples exactly the cycle where its result is due. The pulse width is confirmed by sampling one further falling edge, and same-cycle read and write ordering is checked by reading twice.

// File: rtl/lcd_regs.sv
module lcd_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              set_frame_done,
  input  logic              set_palette_done,
  input  logic              set_sync_error,
  output logic              irq,
  output logic              en_change,
  output logic              panel_on,
  output logic              bad_access
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_TIM0 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_TIM1 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_TIM2 = ADDR_W'(8'h0c);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_SUBP = ADDR_W'(8'h14);
  localparam logic [31:0] CTRL_KEEP  = 32'h01cf_f300;
  localparam logic [31:0] CTRL_FIXED = 32'hfe00_0c34;
  localparam logic [31:0] TIM0_FIXED = 32'h0000_000f;
  localparam logic [31:0] TIM2_FIXED = 32'hfc00_0000;
  localparam logic [31:0] SUBP_KEEP  = 32'ha1ff_ffff;

  logic        enable_q, mono_q, tft_q;
  logic [1:0]  ien_q, plm_q;
  logic [31:0] ctrl_q, tim0_q, tim1_q, tim2_q, subp_q;
  logic        frame_q, pal_q, sync_q;
  logic        hit;
  logic [31:0] rd_mux;

  assign hit = (addr == OFF_CTRL) || (addr == OFF_TIM0) || (addr == OFF_TIM1) ||
               (addr == OFF_TIM2) || (addr == OFF_STAT) || (addr == OFF_SUBP);

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_CTRL: rd_mux = ctrl_q | CTRL_FIXED | {8'h0, tft_q, 1'b0, plm_q, 12'h0,
                         tft_q, 2'b0, ien_q, 1'b0, mono_q, enable_q};
      OFF_TIM0: rd_mux = tim0_q | TIM0_FIXED;
      OFF_TIM1: rd_mux = tim1_q;
      OFF_TIM2: rd_mux = tim2_q | TIM2_FIXED;
      OFF_STAT: rd_mux = {25'h0, pal_q, 3'b0, sync_q, 1'b0, frame_q};
      OFF_SUBP: rd_mux = subp_q;
      default:  rd_mux = '0;
    endcase
  end

  assign irq      = (frame_q & ien_q[0]) | (pal_q & ien_q[1]) | sync_q;
  assign panel_on = enable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0; mono_q <= 1'b0; tft_q <= 1'b0;
      ien_q <= '0; plm_q <= '0; ctrl_q <= '0;
      tim0_q <= '0; tim1_q <= '0; tim2_q <= '0; subp_q <= '0;
      frame_q <= 1'b0; pal_q <= 1'b0; sync_q <= 1'b0;
      en_change <= 1'b0; bad_access <= 1'b0; rdata <= '0;
    end else begin
      en_change <= 1'b0;
      if (rd_en) rdata <= rd_mux;
      if ((rd_en || wr_en) && !hit) bad_access <= 1'b1;
      if (wr_en) begin
        case (addr)
          OFF_CTRL: begin
            mono_q <= wdata[1];
            ien_q  <= wdata[4:3];
            tft_q  <= wdata[7];
            plm_q  <= wdata[21:20];
            ctrl_q <= wdata & CTRL_KEEP;
            if (wdata[0] != enable_q) begin
              enable_q  <= wdata[0];
              en_change <= 1'b1;
              if (!wdata[0]) begin
                sync_q <= 1'b0;
                if (wdata[21:20] != 2'd1) frame_q <= 1'b1;
              end
            end
          end
          OFF_TIM0: tim0_q <= wdata;
          OFF_TIM1: tim1_q <= wdata;
          OFF_TIM2: tim2_q <= wdata;
          OFF_SUBP: subp_q <= wdata & SUBP_KEEP;
          default: ;
        endcase
      end
      if (set_frame_done)   frame_q <= 1'b1;
      if (set_palette_done) pal_q   <= 1'b1;
      if (set_sync_error)   sync_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_regs_chk.sv
module lcd_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wbit0,
  input logic              set_sync_error,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic              en_change,
  input logic              bad_access,
  input logic              enable_q,
  input logic              sync_q
);
  logic mapped;
  assign mapped = (addr == ADDR_W'(8'h00)) || (addr == ADDR_W'(8'h04)) ||
                  (addr == ADDR_W'(8'h08)) || (addr == ADDR_W'(8'h0c)) ||
                  (addr == ADDR_W'(8'h10)) || (addr == ADDR_W'(8'h14));

  p_sync_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_sync_error |=> irq);

  p_pulse_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_change |-> $past(wr_en && addr == ADDR_W'(8'h00)));

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h00) && !wbit0 && enable_q && !set_sync_error) |=> !sync_q);

  p_bad_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> bad_access);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == 32'h0 && bad_access));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind lcd_regs lcd_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wbit0(wdata[0]), .set_sync_error(set_sync_error), .rdata(rdata),
  .irq(irq), .en_change(en_change), .bad_access(bad_access),
  .enable_q(enable_q), .sync_q(sync_q)
);

// File: tb/lcd_regs_test.sv
module lcd_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        set_frame_done = 1'b0, set_palette_done = 1'b0, set_sync_error = 1'b0;
  logic        irq, en_change, panel_on, bad_access;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_regs #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .set_frame_done(set_frame_done),
    .set_palette_done(set_palette_done), .set_sync_error(set_sync_error),
    .irq(irq), .en_change(en_change), .panel_on(panel_on), .bad_access(bad_access)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic strobe(input int which);
    set_frame_done = (which == 0);
    set_palette_done = (which == 1);
    set_sync_error = (which == 2);
    @(negedge clk);
    set_frame_done = 1'b0; set_palette_done = 1'b0; set_sync_error = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 en_change", {31'h0, en_change}, 32'h0);
    chk("R1 bad_access", {31'h0, bad_access}, 32'h0);
    rd(8'h00, v); chk("R1 ctrl", v, 32'hfe000c34);
    rd(8'h04, v); chk("R1 tim0", v, 32'h0000000f);
    rd(8'h08, v); chk("R1 tim1", v, 32'h0);
    rd(8'h0c, v); chk("R1 tim2", v, 32'hfc000000);
    rd(8'h10, v); chk("R1 status", v, 32'h0);
    rd(8'h14, v); chk("R1 subpanel", v, 32'h0);
  endtask

  task automatic t_control();
    logic [31:0] v;
    wr(8'h00, 32'h00000080);
    chk("R8 no pulse same enable", {31'h0, en_change}, 32'h0);
    rd(8'h00, v); chk("R2 tft mirror", v, 32'hfe800cb4);
    wr(8'h00, 32'hffffffff);
    chk("R8 pulse on enable", {31'h0, en_change}, 32'h1);
    chk("R8 panel_on", {31'h0, panel_on}, 32'h1);
    rd(8'h00, v); chk("R2 all ones", v, 32'hffffffbf);
    chk("R8 pulse one cycle", {31'h0, en_change}, 32'h0);
    wr(8'h00, 32'h00100000);
    chk("R8 pulse on disable", {31'h0, en_change}, 32'h1);
    rd(8'h10, v); chk("R9 mode 1 no frame done", v, 32'h0);
    rd(8'h00, v); chk("R2 loading mode", v, 32'hfe100c34);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(8'h00, 32'h1);
    strobe(2);
    chk("R7 sync unmasked", {31'h0, irq}, 32'h1);
    rd(8'h10, v); chk("R6 sync bit", v, 32'h4);
    wr(8'h00, 32'h0);
    rd(8'h10, v); chk("R9 disable clears sync sets frame", v, 32'h1);
    chk("R7 masked frame", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h00, 32'h08);
    chk("R7 frame enabled", {31'h0, irq}, 32'h1);
    wr(8'h00, 32'h10);
    chk("R7 frame masked", {31'h0, irq}, 32'h0);
    strobe(1);
    chk("R7 palette enabled", {31'h0, irq}, 32'h1);
    rd(8'h10, v); chk("R6 palette and frame", v, 32'h41);
    wr(8'h00, 32'h00);
    chk("R7 all masked", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_status_ro();
    logic [31:0] v;
    wr(8'h10, 32'hffffffff);
    rd(8'h10, v); chk("R6 write ignored", v, 32'h41);
    chk("R6 irq unchanged", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(8'h04, 32'habcde3f0);
    rd(8'h04, v); chk("R3 tim0", v, 32'habcde3ff);
    wr(8'h08, 32'h5a5a5a5a);
    rd(8'h08, v); chk("R3 tim1", v, 32'h5a5a5a5a);
    wr(8'h0c, 32'h0123abcd);
    rd(8'h0c, v); chk("R4 tim2", v, 32'hfd23abcd);
  endtask

  task automatic t_subpanel();
    logic [31:0] v;
    wr(8'h14, 32'hffffffff);
    rd(8'h14, v); chk("R5 mask ones", v, 32'ha1ffffff);
    wr(8'h14, 32'h5e000001);
    rd(8'h14, v); chk("R5 mask pattern", v, 32'h00000001);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    rd(8'h0c, v);
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, 32'hfd23abcd);
    addr = 8'h0c; wdata = 32'h0; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read before write", rdata, 32'hfd23abcd);
    rd(8'h0c, v); chk("R11 read after write", v, 32'hfc000000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    chk("R10 flag clear before", {31'h0, bad_access}, 32'h0);
    rd(8'h18, v); chk("R10 read zero", v, 32'h0);
    chk("R10 flag set", {31'h0, bad_access}, 32'h1);
    wr(8'h0e, 32'hffffffff);
    rd(8'h0c, v); chk("R10 write no effect", v, 32'hfc000000);
    rd(8'h08, v);
    chk("R10 flag sticky", {31'h0, bad_access}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control();
    t_disable();
    t_irq();
    t_status_ro();
    t_timing();
    t_subpanel();
    t_latency();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule